// File: doc/BRIEF.md
# Keyed-Refresh Watchdog Timer

This block is a down-counting watchdog for a peripheral clock domain. A prescaler turns the clock into ticks, and the counter loses one count per tick. If software does not restart it in time, the counter runs past zero. At that underflow the block pulses an event toward the interrupt logic. It also pulses one of two requests: a non-maskable interrupt request or a reset request, picked by a software bit.

Software restarts the counter through a refresh register. A refresh is valid only as a two-write key: 0x00 followed by 0xFF. The same valid key also starts the counter for the first time after reset. A strap input can instead make the counter run straight out of reset, with its timing taken from strap pins. A debug-halt input can freeze counting when software has allowed that.

Reads are combinational on `rd_addr`. Writes take effect on the rising clock edge where `wr_en` is high. Register addresses: 0 = timing control, 1 = underflow control, 2 = refresh key, 3 = status.

Top module: `wdt_keyed`

## Requirements
- R1: The prescaler select is control bits [2:0]. Codes 0..5 divide the clock by 4, 64, 128, 512, 2048 and 8192. Codes 6 and 7 divide by 8192. While counting, the count falls by exactly one every divider clock cycles.
- R2: The timeout select is control bits [5:4]. Codes 0..3 give periods of 1024, 4096, 8192 and 16384 ticks. A load or reload sets the count to the period minus one. Control reads show the effective select values in these same bit positions, and zeros elsewhere.
- R3: A write of 0xFF to address 2 is a valid refresh only if the previous write to address 2 was 0x00. A valid refresh loads the count and restarts the prescaler phase. A 0xFF with no preceding 0x00 changes nothing. Any other value cancels the pending key. Writes to other addresses leave a pending key intact.
- R4: At underflow, exactly one request pulses for one cycle. With underflow-control bit 0 set, it is `rst_req`; with bit 0 clear, it is `nmi_req`.
- R5: Status (address 3) is readable at any time: bits [13:0] hold the live count and bit 15 holds the underflow flag.
- R6: Underflow is a tick that arrives while the count is zero. The cycle after it, `uflow_evt` is high for that one cycle and the count holds the reloaded value. The counter then keeps running.
- R7: The underflow flag is set by underflow and stays set. A write to address 3 with data bit 7 = 0 clears it; a write with bit 7 = 1 leaves it set.
- R8: When underflow-control bit 1 is set and `dbg_halt` is high, the count and prescaler freeze. When bit 1 is clear, `dbg_halt` has no effect.
- R9: With `strap_auto` low, the count reads 0 and stays there after reset until the first valid refresh starts it. Control-register writes are accepted only before that start.
- R10: With `strap_auto` high, the count is loaded on the first clock after reset from `strap_cks` and `strap_tops`, and counting starts. Control-register writes are then ignored, and control reads return the strap values.
- R11: A valid refresh is accepted at any count value; there is no restricted window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| dbg_halt | input | 1 | Debugger halt indication |
| strap_auto | input | 1 | Auto-start strap |
| strap_cks | input | 3 | Strap prescaler select |
| strap_tops | input | 2 | Strap timeout select |
| nmi_req | output | 1 | Non-maskable interrupt request pulse |
| rst_req | output | 1 | Reset request pulse |
| uflow_evt | output | 1 | Underflow event pulse |

## Verification
The refresh key is driven with several sequences: a lone 0xFF, 0x00 followed by a foreign value and then 0xFF, a key split by a write to another register, and a clean key issued in mid-count. Together these separate a correct key detector from one that ignores order or cancels too eagerly. Counting is run under three divider and period pairs, including the out-of-range divider code. This distinguishes a correct divider table from shifted or truncated ones. Underflow is driven with both action settings, with the debug halt both enabled and disabled, and in both start modes. This separates correct action routing, freeze gating and strap override from designs that route, gate or override wrongly.

// File: rtl/wdt_kr_pkg.sv
package wdt_kr_pkg;
    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_RCTL = 2'd1;
    localparam logic [1:0] ADR_KEY  = 2'd2;
    localparam logic [1:0] ADR_STAT = 2'd3;

    typedef struct packed {
        logic [1:0] tops;
        logic [2:0] cks;
    } wdt_cfg_t;

    // log2 of the clock divider for a prescaler code
    function automatic logic [3:0] cks_shift(input logic [2:0] c);
        case (c)
            3'd0:    return 4'd2;
            3'd1:    return 4'd6;
            3'd2:    return 4'd7;
            3'd3:    return 4'd9;
            3'd4:    return 4'd11;
            default: return 4'd13;
        endcase
    endfunction

    // log2 of the timeout period in ticks for a timeout code
    function automatic logic [3:0] tops_shift(input logic [1:0] t);
        case (t)
            2'd0:    return 4'd10;
            2'd1:    return 4'd12;
            2'd2:    return 4'd13;
            default: return 4'd14;
        endcase
    endfunction
endpackage

// File: rtl/wdt_kr_prescale.sv
module wdt_kr_prescale #(
    parameter int PRE_W = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [3:0] shift,
    output logic       tick
);
    logic [PRE_W-1:0] pre_d, pre_q;
    logic             at_end;

    always_comb begin
        at_end = (pre_q == PRE_W'((32'd1 << shift) - 32'd1));
        tick   = en && !clr && at_end;
        pre_d  = pre_q;
        if (clr)
            pre_d = '0;
        else if (en)
            pre_d = at_end ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/wdt_kr_key.sv
module wdt_kr_key #(
    parameter logic [7:0] KEY_ARM  = 8'h00,
    parameter logic [7:0] KEY_FIRE = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    output logic       refresh_ok
);
    logic armed_d, armed_q;

    always_comb begin
        refresh_ok = key_wr && armed_q && (key_data == KEY_FIRE);
        armed_d    = key_wr ? (key_data == KEY_ARM) : armed_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_kr_pkg::*;
#(
    parameter int CNT_W = 14,
    parameter int PRE_W = 13,
    parameter int RD_W  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [7:0]      wr_data,
    input  logic [1:0]      rd_addr,
    output logic [RD_W-1:0] rd_data,
    input  logic            dbg_halt,
    input  logic            strap_auto,
    input  logic [2:0]      strap_cks,
    input  logic [1:0]      strap_tops,
    output logic            nmi_req,
    output logic            rst_req,
    output logic            uflow_evt
);
    localparam int FLAG_BIT = RD_W - 1;

    typedef struct packed {
        wdt_cfg_t         ctrl;
        logic             running;
        logic [CNT_W-1:0] count;
        logic             flag;
        logic             action;
        logic             dbgen;
        logic             evt;
        logic             nmi;
        logic             rst;
    } state_t;

    state_t           st_d, st_q;
    wdt_cfg_t         cfg_eff;
    logic [CNT_W-1:0] reload;
    logic             key_wr, refresh_ok, autoload, pre_clr, pre_en, tick, uf;
    logic             unused_bits;

    assign unused_bits = ^{wr_data[6], wr_data[3]};

    always_comb begin
        cfg_eff  = strap_auto ? '{tops: strap_tops, cks: strap_cks} : st_q.ctrl;
        reload   = CNT_W'((32'd1 << tops_shift(cfg_eff.tops)) - 32'd1);
        key_wr   = wr_en && (wr_addr == ADR_KEY);
        autoload = strap_auto && !st_q.running;
        pre_clr  = refresh_ok || autoload;
        pre_en   = st_q.running && !(st_q.dbgen && dbg_halt);
    end

    wdt_kr_key u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_wr     (key_wr),
        .key_data   (wr_data),
        .refresh_ok (refresh_ok)
    );

    wdt_kr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .en    (pre_en),
        .shift (cks_shift(cfg_eff.cks)),
        .tick  (tick)
    );

    always_comb begin
        st_d = st_q;
        uf   = 1'b0;
        if (pre_clr) begin
            st_d.count   = reload;
            st_d.running = 1'b1;
        end else if (tick) begin
            if (st_q.count == '0) begin
                uf         = 1'b1;
                st_d.count = reload;
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end
        st_d.evt = uf;
        st_d.nmi = uf && !st_q.action;
        st_d.rst = uf && st_q.action;
        if (wr_en && (wr_addr == ADR_STAT) && !wr_data[7])
            st_d.flag = 1'b0;
        if (uf)
            st_d.flag = 1'b1;
        if (wr_en && (wr_addr == ADR_CTRL) && !strap_auto && !st_q.running)
            st_d.ctrl = '{tops: wr_data[5:4], cks: wr_data[2:0]};
        if (wr_en && (wr_addr == ADR_RCTL)) begin
            st_d.action = wr_data[0];
            st_d.dbgen  = wr_data[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_CTRL: begin
                rd_data[2:0] = cfg_eff.cks;
                rd_data[5:4] = cfg_eff.tops;
            end
            ADR_RCTL: begin
                rd_data[0] = st_q.action;
                rd_data[1] = st_q.dbgen;
            end
            ADR_STAT: begin
                rd_data[CNT_W-1:0] = st_q.count;
                rd_data[FLAG_BIT]  = st_q.flag;
            end
            default: rd_data = '0;
        endcase
    end

    assign nmi_req   = st_q.nmi;
    assign rst_req   = st_q.rst;
    assign uflow_evt = st_q.evt;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [7:0]       wr_data,
    input logic             dbg_halt,
    input logic             strap_auto,
    input logic             nmi_req,
    input logic             rst_req,
    input logic             uflow_evt,
    input logic             running,
    input logic             dbgen,
    input logic [CNT_W-1:0] count,
    input logic             flag,
    input logic [4:0]       ctrl
);
    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({nmi_req, rst_req}) <= 1); // R4
    AST_REQ_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req || rst_req) == uflow_evt); // R4
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_evt |=> !uflow_evt); // R6
    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_evt |-> flag); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_en && wr_addr == 2'd3 && !wr_data[7])) |=> flag); // R7
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && dbgen && dbg_halt && !(wr_en && wr_addr == 2'd2)) |=> $stable(count)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !strap_auto) |-> (count == '0)); // R9
    AST_CTRL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && (running || strap_auto)) |=> $stable(ctrl)); // R10
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .dbg_halt   (dbg_halt),
    .strap_auto (strap_auto),
    .nmi_req    (nmi_req),
    .rst_req    (rst_req),
    .uflow_evt  (uflow_evt),
    .running    (st_q.running),
    .dbgen      (st_q.dbgen),
    .count      (st_q.count),
    .flag       (st_q.flag),
    .ctrl       (st_q.ctrl)
);

// File: tb/tb_wdt_keyed.sv
module tb_wdt_keyed;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_addr = 2'd3;
    logic [15:0] rd_data;
    logic        dbg_halt = 1'b0;
    logic        strap_auto = 1'b0;
    logic [2:0]  strap_cks = '0;
    logic [1:0]  strap_tops = '0;
    logic        nmi_req, rst_req, uflow_evt;

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    int m_count, m_pre, m_run, m_armed, m_flag, m_ctrl, m_action, m_dbgen;
    int m_evt, m_nmi, m_rst;

    always #5 clk = ~clk;

    wdt_keyed dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .dbg_halt(dbg_halt),
        .strap_auto(strap_auto), .strap_cks(strap_cks), .strap_tops(strap_tops),
        .nmi_req(nmi_req), .rst_req(rst_req), .uflow_evt(uflow_evt)
    );

    function automatic int div_of(input int c);
        case (c)
            0: return 4;
            1: return 64;
            2: return 128;
            3: return 512;
            4: return 2048;
            default: return 8192;
        endcase
    endfunction

    function automatic int per_of(input int t);
        case (t)
            0: return 1024;
            1: return 4096;
            2: return 8192;
            default: return 16384;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 0; m_pre = 0; m_run = 0; m_armed = 0; m_flag = 0;
            m_ctrl = 0; m_action = 0; m_dbgen = 0; m_evt = 0; m_nmi = 0; m_rst = 0;
        end else begin
            int cks, tops, dv, per, run_old, refresh, uf, halted;
            cks     = strap_auto ? int'(strap_cks) : (m_ctrl & 7);
            tops    = strap_auto ? int'(strap_tops) : ((m_ctrl >> 4) & 3);
            dv      = div_of(cks);
            per     = per_of(tops);
            run_old = m_run;
            halted  = m_dbgen && dbg_halt;
            refresh = wr_en && wr_addr == 2 && wr_data == 8'hFF && m_armed;
            uf      = 0;
            if (refresh || (strap_auto && !m_run)) begin
                m_count = per - 1; m_pre = 0; m_run = 1;
            end else if (m_run && !halted) begin
                if (m_pre == dv - 1) begin
                    m_pre = 0;
                    if (m_count == 0) begin uf = 1; m_count = per - 1; end
                    else m_count--;
                end else m_pre++;
            end
            m_evt = uf;
            m_nmi = uf && !m_action;
            m_rst = uf && m_action;
            if (wr_en && wr_addr == 2) m_armed = (wr_data == 8'h00);
            if (wr_en && wr_addr == 3 && !wr_data[7]) m_flag = 0;
            if (uf) m_flag = 1;
            if (wr_en && wr_addr == 0 && !strap_auto && !run_old) m_ctrl = wr_data & 8'h37;
            if (wr_en && wr_addr == 1) begin
                m_action = wr_data[0];
                m_dbgen  = wr_data[1];
            end
        end
    end

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 nmi_req vs model", nmi_req, m_nmi);
            chk("R4 rst_req vs model", rst_req, m_rst);
            chk("R6 uflow_evt vs model", uflow_evt, m_evt);
            if (rd_addr == 2'd3)
                chk("R5 status vs model", rd_data, (m_flag << 15) | m_count);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        #2 rd_addr = a;
        #1 v = rd_data;
        rd_addr = 2'd3;
        #1;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic auto_mode);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; dbg_halt = 1'b0; strap_auto = auto_mode;
        cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic wait_evt();
        for (int i = 0; i < 20000 && !uflow_evt; i++) @(negedge clk);
    endtask

    task automatic run_tests();
        int v, c0;
        // register-start mode, defaults
        do_reset(1'b0);
        rd(2'd3, v); chk("R9 status after reset", v, 0);
        chk("R4 no request after reset", nmi_req | rst_req | uflow_evt, 0);
        rd(2'd0, v); chk("R2 control reset value", v, 0);
        cyc(20);
        rd(2'd3, v); chk("R9 stopped before first refresh", v, 0);
        wr(2'd2, 8'hFF); cyc(5);
        rd(2'd3, v); chk("R3 lone 0xFF ignored", v, 0);
        wr(2'd2, 8'h00); wr(2'd2, 8'h55); wr(2'd2, 8'hFF); cyc(3);
        rd(2'd3, v); chk("R3 foreign value cancels key", v, 0);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R1 control write before start", v, 0);
        wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'hFF);
        rd(2'd3, v); chk("R3 key split by other address starts count", v, 1023);
        cyc(40);
        rd(2'd3, v); chk("R1 divide by 4 rate", v, 1013);
        wr(2'd0, 8'h35);
        rd(2'd0, v); chk("R9 control locked while running", v, 0);
        // debug halt enabled
        wr(2'd1, 8'h02); dbg_halt = 1'b1;
        rd(2'd3, c0); cyc(50);
        rd(2'd3, v); chk("R8 halt freezes count", v, c0);
        dbg_halt = 1'b0;
        // debug halt disabled
        wr(2'd1, 8'h00); dbg_halt = 1'b1;
        rd(2'd3, c0); cyc(40);
        rd(2'd3, v); chk("R8 halt ignored when disabled", v, c0 - 10);
        dbg_halt = 1'b0;
        // refresh mid-count
        wr(2'd2, 8'h00); wr(2'd2, 8'hFF);
        rd(2'd3, v); chk("R11 refresh accepted mid-count", v, 1023);
        // underflow with interrupt action
        wait_evt();
        chk("R6 underflow event seen", uflow_evt, 1);
        chk("R4 nmi on underflow", nmi_req, 1);
        chk("R4 no reset on nmi action", rst_req, 0);
        rd(2'd3, v); chk("R6 R7 reload and flag", v, 32'h8000 | 1023);
        cyc(1);
        chk("R6 event lasts one cycle", uflow_evt, 0);
        wr(2'd3, 8'h80);
        rd(2'd3, v); chk("R7 flag kept on bit7=1", (v >> 15) & 1, 1);
        wr(2'd3, 8'h00);
        rd(2'd3, v); chk("R7 flag cleared", (v >> 15) & 1, 0);
        // underflow with reset action
        wr(2'd1, 8'h01);
        wait_evt();
        chk("R4 reset on underflow", rst_req, 1);
        chk("R4 no nmi on reset action", nmi_req, 0);
        // divide by 64, 4096 ticks
        do_reset(1'b0);
        wr(2'd0, 8'h11);
        rd(2'd0, v); chk("R2 control readback 0x11", v, 32'h11);
        wr(2'd2, 8'h00); wr(2'd2, 8'hFF);
        rd(2'd3, v); chk("R2 period 4096 load", v, 4095);
        cyc(64 * 3);
        rd(2'd3, v); chk("R1 divide by 64 rate", v, 4092);
        // out-of-range divider code, 16384 ticks
        do_reset(1'b0);
        wr(2'd0, 8'h37);
        wr(2'd2, 8'h00); wr(2'd2, 8'hFF);
        rd(2'd3, v); chk("R2 period 16384 load", v, 16383);
        cyc(8192 * 2);
        rd(2'd3, v); chk("R1 code 7 divides by 8192", v, 16381);
        // auto-start strap
        strap_cks = 3'd0; strap_tops = 2'd1;
        do_reset(1'b1);
        cyc(1);
        rd(2'd3, v); chk("R10 auto load on first clock", v, 4095);
        rd(2'd0, v); chk("R10 control shows strap", v, 32'h10);
        wr(2'd0, 8'h05);
        rd(2'd0, v); chk("R10 control write ignored", v, 32'h10);
        wait_evt();
        chk("R10 auto mode underflows with nmi", nmi_req, 1);
    endtask

    initial begin
        fork
            run_tests();
            begin
                cyc(150000);
                failures++;
                $display("FAIL R5 watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule